// File: doc/BRIEF.md
# Video Window Cropper with Committed Geometry

The block cuts a rectangular window out of a video stream that arrives one pixel per beat in raster order. Each input beat carries a start-of-frame flag, an end-of-line flag and an end-of-frame flag. Pixels inside the window are passed through unchanged. Pixels outside it are consumed and discarded. The output stream has its own start, end-of-line and end-of-frame flags, placed on the window's pixels.

Software programs the window through a small register port with word-aligned byte addresses. Geometry writes go to a shadow set. A write to the commit address arms a copy of the shadow set into the active set. That copy takes place on the first beat of the next input frame, so every frame is cropped with a single, consistent window.

A build-time parameter selects how the window is described. In offset mode the four geometry values are margins removed from each edge. In dimension mode they are a corner position followed by an output width and an output height.

Top module: `video_clipper`

## Requirements
- R1: Reading address 0x000 returns 0x6AF7022D. Reading address 0x010 returns the window mode in bit 0: 0 for offset mode, 1 for dimension mode.
- R2: In offset mode (DIM_MODE=0), geometry words g0..g3 at 0x148, 0x14C, 0x150 and 0x154 are the left, top, right and bottom margins. A pixel at column x, row y is kept when g0 <= x < W-g2 and g1 <= y < H-g3.
- R3: In dimension mode (DIM_MODE=1), g0 and g1 are the corner column and row, and g2 and g3 are the output width and height. A pixel is kept when g0 <= x < min(g0+g2, W) and g1 <= y < min(g1+g3, H).
- R4: A window that runs past the frame is clamped to the frame edge. A window with no columns or no rows produces no output beats for that frame.
- R5: Geometry writes land in 16-bit shadow registers that read back at the same addresses. Without a commit they never change the window that is applied.
- R6: A write of any value to 0x144 arms a transfer of the shadow set to the active set. The transfer happens on the first input beat after an end-of-frame beat, or after reset. The new window applies from that beat onward. A commit made mid-frame therefore has no effect until the next frame.
- R7: Status register 0x140 bit 1 is set by any geometry write. It clears only on the first frame start that follows a commit.
- R8: Status bit 0 is 1 from the first accepted beat of a frame until its end-of-frame beat is accepted, and 0 otherwise.
- R9: Dropped input beats are accepted with in_ready_o=1 whatever out_ready_i is. For kept beats, in_ready_o equals out_ready_i. out_valid_o is high only for kept beats with in_valid_i high, and the data passes through unchanged.
- R10: out_sof_o marks the first kept pixel of a frame. out_eol_o marks the last kept pixel of every kept row. out_eof_o marks the last kept pixel of the last kept row.
- R11: Registers 0x120 and 0x124 (16 bits) give the input width W and height H used for the window bounds. The input column restarts after an end-of-line beat, and both column and row restart after end-of-frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | ADDR_W | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_we_i | input | 1 | Register write strobe |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| in_valid_i | input | 1 | Input pixel valid |
| in_ready_o | output | 1 | Input pixel accepted |
| in_data_i | input | DATA_W | Input pixel |
| in_sof_i | input | 1 | Input first pixel of frame |
| in_eol_i | input | 1 | Input last pixel of line |
| in_eof_i | input | 1 | Input last pixel of frame |
| out_valid_o | output | 1 | Output pixel valid |
| out_ready_i | input | 1 | Downstream ready |
| out_data_o | output | DATA_W | Output pixel |
| out_sof_o | output | 1 | Output first pixel of frame |
| out_eol_o | output | 1 | Output last pixel of line |
| out_eof_o | output | 1 | Output last pixel of frame |

## Verification
The cropping function is exercised in both modes with several kinds of window:
- Centred windows, which show that each edge bound is placed correctly.
- Margins or extents larger than the frame, which separate clamping from wrap-around.
- Zero-size windows, which must produce no output at all.
- Random frame sizes and geometries under random downstream stalls, which separate stalls on kept pixels from free acceptance of dropped pixels.

Geometry writes with and without a commit, and commits made in the middle of a frame, show whether the shadow set stays apart from the active set until the frame boundary.

// File: rtl/clip_pkg.sv
package clip_pkg;
  localparam int unsigned DIM_W  = 16;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned N_GEOM = 4;

  localparam int A_ID     = 'h000;
  localparam int A_MODE   = 'h010;
  localparam int A_WIDTH  = 'h120;
  localparam int A_HEIGHT = 'h124;
  localparam int A_STATUS = 'h140;
  localparam int A_COMMIT = 'h144;
  localparam int A_GEOM0  = 'h148;

  localparam logic [REG_W-1:0] ID_VALUE = 32'h6AF7_022D;

  // horiz/vert: right/bottom margin in offset mode, width/height in dimension mode
  typedef struct packed {
    logic [DIM_W-1:0] left;
    logic [DIM_W-1:0] top;
    logic [DIM_W-1:0] horiz;
    logic [DIM_W-1:0] vert;
  } geom_t;

  // hi bounds are exclusive
  typedef struct packed {
    logic [DIM_W-1:0] x_lo;
    logic [DIM_W-1:0] x_hi;
    logic [DIM_W-1:0] y_lo;
    logic [DIM_W-1:0] y_hi;
    logic             empty;
  } win_t;
endpackage

// File: rtl/clip_regs.sv
module clip_regs
  import clip_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter bit          DIM_MODE = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DIM_W-1:0]  wdata_i,
  input  logic              we_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              start_sel_i,
  input  logic              start_fire_i,
  input  logic              busy_i,
  output geom_t             geom_o,
  output logic [DIM_W-1:0]  frame_w_o,
  output logic [DIM_W-1:0]  frame_h_o,
  output logic              pending_o
);
  logic [N_GEOM-1:0] geom_hit;
  logic [DIM_W-1:0]  shadow_q [N_GEOM];
  logic [DIM_W-1:0]  active_q [N_GEOM];
  logic [DIM_W-1:0]  frame_w_q, frame_h_q;
  logic              armed_q, pending_q;
  logic              commit_hit, w_hit, h_hit, take;

  for (genvar k = 0; k < N_GEOM; k++) begin : g_hit
    assign geom_hit[k] = we_i && (addr_i == ADDR_W'(A_GEOM0 + 4 * k));
  end

  assign commit_hit = we_i && (addr_i == ADDR_W'(A_COMMIT));
  assign w_hit      = we_i && (addr_i == ADDR_W'(A_WIDTH));
  assign h_hit      = we_i && (addr_i == ADDR_W'(A_HEIGHT));
  assign take       = start_sel_i && armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < N_GEOM; k++) begin
        shadow_q[k] <= '0;
        active_q[k] <= '0;
      end
      frame_w_q <= '0;
      frame_h_q <= '0;
      armed_q   <= 1'b0;
      pending_q <= 1'b0;
    end else begin
      for (int k = 0; k < N_GEOM; k++) begin
        if (geom_hit[k]) shadow_q[k] <= wdata_i;
      end
      if (w_hit) frame_w_q <= wdata_i;
      if (h_hit) frame_h_q <= wdata_i;
      if (start_fire_i && armed_q) begin
        for (int k = 0; k < N_GEOM; k++) active_q[k] <= shadow_q[k];
        armed_q   <= 1'b0;
        pending_q <= 1'b0;
      end
      // later writes win over a same-cycle transfer
      if (commit_hit) armed_q <= 1'b1;
      if (|geom_hit) pending_q <= 1'b1;
    end
  end

  // the start beat already sees the committed set
  always_comb begin
    if (take) begin
      geom_o = '{left: shadow_q[0], top: shadow_q[1], horiz: shadow_q[2], vert: shadow_q[3]};
    end else begin
      geom_o = '{left: active_q[0], top: active_q[1], horiz: active_q[2], vert: active_q[3]};
    end
  end

  assign frame_w_o = frame_w_q;
  assign frame_h_o = frame_h_q;
  assign pending_o = pending_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(A_ID):        rdata_o = ID_VALUE;
      ADDR_W'(A_MODE):      rdata_o = {{(REG_W-1){1'b0}}, DIM_MODE};
      ADDR_W'(A_WIDTH):     rdata_o = {{(REG_W-DIM_W){1'b0}}, frame_w_q};
      ADDR_W'(A_HEIGHT):    rdata_o = {{(REG_W-DIM_W){1'b0}}, frame_h_q};
      ADDR_W'(A_STATUS):    rdata_o = {{(REG_W-2){1'b0}}, pending_q, busy_i};
      ADDR_W'(A_GEOM0):     rdata_o = {{(REG_W-DIM_W){1'b0}}, shadow_q[0]};
      ADDR_W'(A_GEOM0 + 4): rdata_o = {{(REG_W-DIM_W){1'b0}}, shadow_q[1]};
      ADDR_W'(A_GEOM0 + 8): rdata_o = {{(REG_W-DIM_W){1'b0}}, shadow_q[2]};
      ADDR_W'(A_GEOM0 + 12):rdata_o = {{(REG_W-DIM_W){1'b0}}, shadow_q[3]};
      default:              rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/clip_window.sv
module clip_window
  import clip_pkg::*;
#(
  parameter bit DIM_MODE = 1'b0
) (
  input  geom_t            geom_i,
  input  logic [DIM_W-1:0] frame_w_i,
  input  logic [DIM_W-1:0] frame_h_i,
  output win_t             win_o
);
  logic [DIM_W-1:0] x_hi, y_hi;

  function automatic logic [DIM_W-1:0] hi_from_margin(logic [DIM_W-1:0] size,
                                                     logic [DIM_W-1:0] margin);
    return (margin >= size) ? '0 : size - margin;
  endfunction

  function automatic logic [DIM_W-1:0] hi_from_extent(logic [DIM_W-1:0] size,
                                                     logic [DIM_W-1:0] lo,
                                                     logic [DIM_W-1:0] ext);
    logic [DIM_W:0] sum;
    sum = {1'b0, lo} + {1'b0, ext};
    return (sum > {1'b0, size}) ? size : sum[DIM_W-1:0];
  endfunction

  if (DIM_MODE) begin : g_dims
    assign x_hi = hi_from_extent(frame_w_i, geom_i.left, geom_i.horiz);
    assign y_hi = hi_from_extent(frame_h_i, geom_i.top, geom_i.vert);
  end else begin : g_offs
    assign x_hi = hi_from_margin(frame_w_i, geom_i.horiz);
    assign y_hi = hi_from_margin(frame_h_i, geom_i.vert);
  end

  assign win_o.x_lo  = geom_i.left;
  assign win_o.y_lo  = geom_i.top;
  assign win_o.x_hi  = x_hi;
  assign win_o.y_hi  = y_hi;
  assign win_o.empty = (geom_i.left >= x_hi) || (geom_i.top >= y_hi);
endmodule

// File: rtl/clip_stream.sv
module clip_stream
  import clip_pkg::*;
#(
  parameter int unsigned DATA_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  win_t              win_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_sof_i,
  input  logic              in_eol_i,
  input  logic              in_eof_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_sof_o,
  output logic              out_eol_o,
  output logic              out_eof_o,
  output logic              busy_o,
  output logic              start_sel_o,
  output logic              start_fire_o
);
  logic [DIM_W-1:0] x_q, y_q, x_cur, y_cur;
  logic             busy_q, keep, fire, last_col;

  assign x_cur = in_sof_i ? '0 : x_q;
  assign y_cur = in_sof_i ? '0 : y_q;

  assign keep = !win_i.empty
             && (x_cur >= win_i.x_lo) && (x_cur < win_i.x_hi)
             && (y_cur >= win_i.y_lo) && (y_cur < win_i.y_hi);

  assign last_col = (x_cur == win_i.x_hi - 1'b1);

  assign in_ready_o  = keep ? out_ready_i : 1'b1;
  assign fire        = in_valid_i && in_ready_o;
  assign out_valid_o = in_valid_i && keep;
  assign out_data_o  = in_data_i;
  assign out_sof_o   = keep && (x_cur == win_i.x_lo) && (y_cur == win_i.y_lo);
  assign out_eol_o   = keep && last_col;
  assign out_eof_o   = keep && last_col && (y_cur == win_i.y_hi - 1'b1);

  assign start_sel_o  = in_valid_i && !busy_q;
  assign start_fire_o = start_sel_o && in_ready_o;
  assign busy_o       = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q    <= '0;
      y_q    <= '0;
      busy_q <= 1'b0;
    end else if (fire) begin
      if (in_eof_i) begin
        x_q    <= '0;
        y_q    <= '0;
        busy_q <= 1'b0;
      end else if (in_eol_i) begin
        x_q    <= '0;
        y_q    <= y_cur + 1'b1;
        busy_q <= 1'b1;
      end else begin
        x_q    <= x_cur + 1'b1;
        y_q    <= y_cur;
        busy_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/video_clipper.sv
module video_clipper
  import clip_pkg::*;
#(
  parameter int unsigned DATA_W   = 24,
  parameter int unsigned ADDR_W   = 12,
  parameter bit          DIM_MODE = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  input  logic              reg_we_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_sof_i,
  input  logic              in_eol_i,
  input  logic              in_eof_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_sof_o,
  output logic              out_eol_o,
  output logic              out_eof_o
);
  geom_t            geom;
  win_t             win;
  logic [DIM_W-1:0] frame_w, frame_h;
  logic             busy, pending, start_sel, start_fire;
  logic             unused_wdata;

  assign unused_wdata = ^reg_wdata_i[31:DIM_W];

  clip_regs #(.ADDR_W(ADDR_W), .DIM_MODE(DIM_MODE)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i[DIM_W-1:0]),
    .we_i        (reg_we_i),
    .rdata_o     (reg_rdata_o),
    .start_sel_i (start_sel),
    .start_fire_i(start_fire),
    .busy_i      (busy),
    .geom_o      (geom),
    .frame_w_o   (frame_w),
    .frame_h_o   (frame_h),
    .pending_o   (pending)
  );

  clip_window #(.DIM_MODE(DIM_MODE)) u_window (
    .geom_i   (geom),
    .frame_w_i(frame_w),
    .frame_h_i(frame_h),
    .win_o    (win)
  );

  clip_stream #(.DATA_W(DATA_W)) u_stream (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .win_i       (win),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .in_data_i   (in_data_i),
    .in_sof_i    (in_sof_i),
    .in_eol_i    (in_eol_i),
    .in_eof_i    (in_eof_i),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_data_o  (out_data_o),
    .out_sof_o   (out_sof_o),
    .out_eol_o   (out_eol_o),
    .out_eof_o   (out_eof_o),
    .busy_o      (busy),
    .start_sel_o (start_sel),
    .start_fire_o(start_fire)
  );
endmodule

// File: rtl/clip_checker.sv
module clip_checker #(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              reg_we_i,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic [DATA_W-1:0] in_data_i,
  input logic              in_eof_i,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [DATA_W-1:0] out_data_o,
  input logic              out_eol_o,
  input logic              out_eof_o,
  input logic              pending_i,
  input logic              busy_i
);
  logic geom_wr, in_fire;
  assign geom_wr = reg_we_i && (reg_addr_i >= ADDR_W'('h148))
                && (reg_addr_i <= ADDR_W'('h154)) && (reg_addr_i[1:0] == 2'b00);
  assign in_fire = in_valid_i && in_ready_o;

  assert_drop_ready_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !out_valid_o) |-> in_ready_o);
  assert_kept_ready_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (in_ready_o == out_ready_i));
  assert_valid_source_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (in_valid_i && out_data_o == in_data_i));
  assert_eof_on_eol_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_eof_o) |-> out_eol_o);
  assert_pending_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    geom_wr |=> pending_i);
  assert_busy_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_fire && in_eof_i) |=> !busy_i);
  assert_busy_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_fire && !in_eof_i) |=> busy_i);
endmodule

bind video_clipper clip_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_clip_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_addr_i (reg_addr_i),
  .reg_we_i   (reg_we_i),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .in_data_i  (in_data_i),
  .in_eof_i   (in_eof_i),
  .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i),
  .out_data_o (out_data_o),
  .out_eol_o  (out_eol_o),
  .out_eof_o  (out_eof_o),
  .pending_i  (pending),
  .busy_i     (busy)
);

// File: tb/video_clipper_bench.sv
module video_clipper_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        we [2];
  logic [31:0] rdata [2];
  logic        vin [2];
  logic        in_rdy [2];
  logic [23:0] in_data = '0;
  logic        sof = 1'b0, eol = 1'b0, eof = 1'b0, out_ready = 1'b0;
  logic        ov [2];
  logic [23:0] od [2];
  logic        osof [2], oeol [2], oeof [2];

  int n_checks = 0, n_err = 0;
  int W, H;
  int shadow [2][4];
  int active [2][4];
  bit armed [2];
  bit pending [2];
  int out_cnt;

  always #10 clk = ~clk;

  video_clipper #(.DATA_W(24), .ADDR_W(12), .DIM_MODE(1'b0)) u_video_clipper (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_we_i(we[0]), .reg_rdata_o(rdata[0]), .in_valid_i(vin[0]), .in_ready_o(in_rdy[0]),
    .in_data_i(in_data), .in_sof_i(sof), .in_eol_i(eol), .in_eof_i(eof),
    .out_valid_o(ov[0]), .out_ready_i(out_ready), .out_data_o(od[0]),
    .out_sof_o(osof[0]), .out_eol_o(oeol[0]), .out_eof_o(oeof[0]));

  video_clipper #(.DATA_W(24), .ADDR_W(12), .DIM_MODE(1'b1)) u_video_clipper_dim (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_we_i(we[1]), .reg_rdata_o(rdata[1]), .in_valid_i(vin[1]), .in_ready_o(in_rdy[1]),
    .in_data_i(in_data), .in_sof_i(sof), .in_eol_i(eol), .in_eof_i(eof),
    .out_valid_o(ov[1]), .out_ready_i(out_ready), .out_data_o(od[1]),
    .out_sof_o(osof[1]), .out_eol_o(oeol[1]), .out_eof_o(oeof[1]));

  task automatic check(bit ok, string req, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int x_end(int s);
    if (s == 0) return W - active[s][2];
    return (active[s][0] + active[s][2] < W) ? active[s][0] + active[s][2] : W;
  endfunction

  function automatic int y_end(int s);
    if (s == 0) return H - active[s][3];
    return (active[s][1] + active[s][3] < H) ? active[s][1] + active[s][3] : H;
  endfunction

  function automatic bit exp_keep(int s, int x, int y);
    return x >= active[s][0] && x < x_end(s) && y >= active[s][1] && y < y_end(s);
  endfunction

  task automatic wr(int s, int a, int d);
    @(negedge clk);
    reg_addr = 12'(a);
    reg_wdata = d;
    we[s] = 1'b1;
    @(negedge clk);
    we[s] = 1'b0;
    if (a >= 'h148 && a <= 'h154) begin
      shadow[s][(a - 'h148) / 4] = d & 'hffff;
      pending[s] = 1'b1;
    end
    if (a == 'h144) armed[s] = 1'b1;
  endtask

  task automatic rd(int s, int a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = 12'(a);
    #2 v = rdata[s];
  endtask

  task automatic set_geom(int s, int g0, int g1, int g2, int g3, bit commit);
    wr(s, 'h148, g0);
    wr(s, 'h14C, g1);
    wr(s, 'h150, g2);
    wr(s, 'h154, g3);
    if (commit) wr(s, 'h144, $urandom);
  endtask

  task automatic set_dims(int w, int h);
    W = w;
    H = h;
    for (int s = 0; s < 2; s++) begin
      wr(s, 'h120, w);
      wr(s, 'h124, h);
    end
  endtask

  task automatic check_status(int s, bit busy_exp, string tag);
    logic [31:0] v;
    rd(s, 'h140, v);
    check(v[0] == busy_exp, "R8", v[0], busy_exp);
    check(v[1] == pending[s], tag, v[1], pending[s]);
  endtask

  task automatic send_rows(int s, int y_from, int y_to, string tag);
    if (y_from == 0) out_cnt = 0;
    for (int y = y_from; y < y_to; y++) begin
      for (int x = 0; x < W; x++) begin
        bit done;
        done = 1'b0;
        @(negedge clk);
        if (x == 0 && y == 0 && armed[s]) begin
          active[s] = shadow[s];
          armed[s] = 1'b0;
          pending[s] = 1'b0;
        end
        in_data = 24'($urandom);
        sof = (x == 0 && y == 0);
        eol = (x == W - 1);
        eof = (x == W - 1 && y == H - 1);
        vin[s] = 1'b1;
        while (!done) begin
          bit k, e_sof, e_eol, e_eof, e_rdy;
          out_ready = ($urandom % 4) != 0;
          #8;
          k = exp_keep(s, x, y);
          e_rdy = k ? out_ready : 1'b1;
          e_eol = k && (x == x_end(s) - 1);
          e_eof = e_eol && (y == y_end(s) - 1);
          e_sof = k && x == active[s][0] && y == active[s][1];
          check(ov[s] == k, (s == 0) ? "R2" : "R3", ov[s], k);
          check(in_rdy[s] == e_rdy, "R9", in_rdy[s], e_rdy);
          if (k) begin
            check(od[s] == in_data, "R9", od[s], in_data);
            check({osof[s], oeol[s], oeof[s]} == {e_sof, e_eol, e_eof}, "R10",
                  {osof[s], oeol[s], oeof[s]}, {e_sof, e_eol, e_eof});
          end
          done = in_rdy[s];
          if (ov[s] && out_ready) out_cnt++;
          @(posedge clk);
          if (!done) @(negedge clk);
        end
      end
    end
    @(negedge clk);
    vin[s] = 1'b0;
    if (y_to == H) begin
      int exp_cnt;
      exp_cnt = 0;
      for (int y = 0; y < H; y++)
        for (int x = 0; x < W; x++)
          if (exp_keep(s, x, y)) exp_cnt++;
      check(out_cnt == exp_cnt, tag, out_cnt, exp_cnt);
    end
  endtask

  task automatic send_frame(int s, string tag);
    send_rows(s, 0, H, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(1234));
    for (int s = 0; s < 2; s++) begin
      we[s] = 1'b0;
      vin[s] = 1'b0;
      armed[s] = 1'b0;
      pending[s] = 1'b0;
      for (int k = 0; k < 4; k++) begin
        shadow[s][k] = 0;
        active[s][k] = 0;
      end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state and identity
    for (int s = 0; s < 2; s++) begin
      check(ov[s] == 1'b0, "R9", ov[s], 0);
      check_status(s, 1'b0, "R7");
      rd(s, 'h000, v);
      check(v == 32'h6AF7022D, "R1", v, 32'h6AF7022D);
      rd(s, 'h010, v);
      check(v == 32'(s), "R1", v, s);
      rd(s, 'h150, v);
      check(v == 0, "R5", v, 0);
    end

    set_dims(8, 6);
    rd(0, 'h120, v);
    check(v == 8, "R11", v, 8);

    // centred windows
    set_geom(0, 1, 1, 2, 1, 1'b1);
    set_geom(1, 2, 1, 3, 4, 1'b1);
    for (int s = 0; s < 2; s++) begin
      check_status(s, 1'b0, "R7");
      send_frame(s, "R6");
      check_status(s, 1'b0, "R7");
    end

    // shadow writes without commit
    for (int s = 0; s < 2; s++) begin
      set_geom(s, 3, 2, 1, 1, 1'b0);
      rd(s, 'h148, v);
      check(v == 3, "R5", v, 3);
      send_frame(s, "R5");
      check_status(s, 1'b0, "R7");
    end

    // commit in the middle of a frame
    for (int s = 0; s < 2; s++) begin
      send_rows(s, 0, 2, "R6");
      set_geom(s, 0, 0, 2, 2, 1'b1);
      check_status(s, 1'b1, "R7");
      send_rows(s, 2, H, "R6");
      check_status(s, 1'b0, "R7");
      send_frame(s, "R6");
      check_status(s, 1'b0, "R7");
    end

    // clamping and empty windows
    set_geom(0, 0, 0, 20, 0, 1'b1);
    send_frame(0, "R4");
    set_geom(0, 2, 7, 0, 0, 1'b1);
    send_frame(0, "R4");
    set_geom(1, 5, 3, 30, 40, 1'b1);
    send_frame(1, "R4");
    set_geom(1, 1, 1, 0, 3, 1'b1);
    send_frame(1, "R4");
    set_geom(1, 9, 0, 2, 2, 1'b1);
    send_frame(1, "R4");

    // frame size change
    set_dims(5, 4);
    set_geom(0, 0, 0, 0, 0, 1'b1);
    set_geom(1, 0, 0, 100, 100, 1'b1);
    for (int s = 0; s < 2; s++) send_frame(s, "R11");

    // random frames and windows
    for (int i = 0; i < 30; i++) begin
      int s;
      s = i % 2;
      if (s == 0) set_dims(1 + $urandom % 12, 1 + $urandom % 10);
      set_geom(s, $urandom % 14, $urandom % 12, $urandom % 14, $urandom % 12,
               ($urandom % 4) != 0);
      send_frame(s, (s == 0) ? "R2" : "R3");
      check_status(s, 1'b0, "R7");
    end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule